// File: doc/BRIEF.md
# Power-Up Recall and Non-Volatile Write Sequencer

This block owns the wiper position byte of a digitally set potentiometer. It also owns the stored start-up byte that is copied into that position at power-up. While the supply is not yet reported good, the wiper sits at mid-scale and the serial bus front end is held deaf. Once the supply has been reported good for a set number of consecutive clocks, the stored byte is copied into the wiper and the bus is released into standby.

The bus front end sends two kinds of request. A volatile load pulse sets the wiper at once. A non-volatile start pulse is raised on the STOP that ends a write meant for persistent storage. That pulse launches a self-timed programming cycle, and the bus stays deaf for the whole cycle. The stored byte is modelled as an on-chip register. It takes the captured value only when the cycle timer runs out. Any request that arrives while the bus is deaf is dropped. If the supply is lost at any point, the block returns to the power-up state and abandons any cycle in flight.

Top module: `nv_recall_seq`

## Requirements
- R1: During and right after reset, `wiper` and `stored` both read 80h, `bus_deaf` is 1 and `nv_busy` is 0.
- R2: While in the power-up phase, `wiper` stays at 80h and `bus_deaf` stays 1. Any `vol_load` or `nv_start` pulse is ignored and leaves `wiper` and `stored` unchanged.
- R3: When `supply_ok` has been sampled high on `PWR_CYCLES` consecutive rising edges, `wiper` takes the value of `stored` and `bus_deaf` falls at that edge. A low sample restarts the count.
- R4: In standby, a `vol_load` pulse sets `wiper` to `vol_data` on the next edge. It leaves `stored` unchanged and starts no timed cycle.
- R5: In standby, an `nv_start` pulse raises `nv_busy` and `bus_deaf` for exactly `NV_CYCLES` clocks. `stored` keeps its old value for the whole of that window.
- R6: At the end of the timed cycle, `stored` holds the `nv_data` value captured with `nv_start`, and `wiper` is unchanged by the cycle.
- R7: While `nv_busy` is 1, `vol_load` and `nv_start` pulses are dropped. `wiper` does not move, and the value committed is the one captured at the start of the cycle.
- R8: A low `supply_ok` returns the block to power-up on the next edge, with `wiper` at 80h, `bus_deaf` 1 and `nv_busy` 0. A cycle in flight is abandoned and `stored` keeps its previous value.
- R9: A `vol_load` and an `nv_start` on the same standby clock both take effect: the wiper loads at once and the stored byte follows at the end of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply reported good |
| vol_load | input | 1 | Pulse: load wiper from `vol_data` |
| vol_data | input | DW | Wiper value for a volatile load |
| nv_start | input | 1 | Pulse on STOP: start timed store cycle |
| nv_data | input | DW | Byte to store at the end of the cycle |
| wiper | output | DW | Current wiper position |
| stored | output | DW | Stored start-up byte |
| bus_deaf | output | 1 | Bus front end must ignore SCL/SDA and release SDA |
| nv_busy | output | 1 | Timed store cycle in progress |

## Verification
The bench builds the block with `PWR_CYCLES` = 5 and `NV_CYCLES` = 12, where the default programming time is millions of clocks. These short values let a run pass through several full store cycles and watch every edge of each one. They also let a supply drop land midway through a cycle and the following recall complete, all in a few hundred clocks. With a power-up window this short, the bench can break the count one edge early and show that the count restarts.

// File: rtl/nvseq_pkg.sv
`timescale 1ns/1ps
package nvseq_pkg;
    typedef enum logic [1:0] {
        SEQ_POWERUP = 2'd0,
        SEQ_STANDBY = 2'd1,
        SEQ_NVCYCLE = 2'd2
    } seq_mode_e;
endpackage

// File: rtl/nvseq_timer.sv
`timescale 1ns/1ps
// Down counter shared by the power-up window and the store cycle.
module nvseq_timer #(
    parameter int unsigned CW          = 8,
    parameter int unsigned RESET_COUNT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(RESET_COUNT);
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvseq_cell.sv
`timescale 1ns/1ps
// Model of the persistent byte: a capture register plus the committed value.
module nvseq_cell #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] capture_data,
    input  logic          commit,
    output logic [DW-1:0] stored
);
    typedef struct packed {
        logic [DW-1:0] pend;
        logic [DW-1:0] value;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (capture) cell_d.pend  = capture_data;
        if (commit)  cell_d.value = cell_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q.pend  <= RESET_VAL;
            cell_q.value <= RESET_VAL;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign stored = cell_q.value;
endmodule

// File: rtl/nv_recall_seq.sv
`timescale 1ns/1ps
module nv_recall_seq
    import nvseq_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned PWR_CYCLES = 64,
    parameter int unsigned NV_CYCLES  = 4000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          vol_load,
    input  logic [DW-1:0] vol_data,
    input  logic          nv_start,
    input  logic [DW-1:0] nv_data,
    output logic [DW-1:0] wiper,
    output logic [DW-1:0] stored,
    output logic          bus_deaf,
    output logic          nv_busy
);
    localparam int unsigned   LONGEST  = (PWR_CYCLES > NV_CYCLES) ? PWR_CYCLES : NV_CYCLES;
    localparam int unsigned   CW       = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] PWR_LOAD = CW'(PWR_CYCLES - 1);
    localparam logic [CW-1:0] NV_LOAD  = CW'(NV_CYCLES - 1);
    localparam logic [DW-1:0] MID      = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        seq_mode_e     mode;
        logic [DW-1:0] wiper;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          cell_capture;
    logic          cell_commit;

    always_comb begin
        seq_d        = seq_q;
        tmr_load     = 1'b0;
        tmr_val      = PWR_LOAD;
        cell_capture = 1'b0;
        cell_commit  = 1'b0;
        if (!supply_ok) begin
            // Supply lost or not yet good: hold mid-scale, rearm the window.
            seq_d.mode  = SEQ_POWERUP;
            seq_d.wiper = MID;
            tmr_load    = 1'b1;
        end else begin
            unique case (seq_q.mode)
                SEQ_POWERUP: begin
                    if (tmr_expired) begin
                        seq_d.mode  = SEQ_STANDBY;
                        seq_d.wiper = stored;
                    end
                end
                SEQ_STANDBY: begin
                    if (vol_load) seq_d.wiper = vol_data;
                    if (nv_start) begin
                        seq_d.mode   = SEQ_NVCYCLE;
                        tmr_load     = 1'b1;
                        tmr_val      = NV_LOAD;
                        cell_capture = 1'b1;
                    end
                end
                SEQ_NVCYCLE: begin
                    if (tmr_expired) begin
                        cell_commit = 1'b1;
                        seq_d.mode  = SEQ_STANDBY;
                    end
                end
                default: begin
                    seq_d.mode  = SEQ_POWERUP;
                    seq_d.wiper = MID;
                    tmr_load    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.mode  <= SEQ_POWERUP;
            seq_q.wiper <= MID;
        end else begin
            seq_q <= seq_d;
        end
    end

    nvseq_timer #(
        .CW          (CW),
        .RESET_COUNT (PWR_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nvseq_cell #(
        .DW        (DW),
        .RESET_VAL (MID)
    ) u_cell (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (cell_capture),
        .capture_data (nv_data),
        .commit       (cell_commit),
        .stored       (stored)
    );

    assign wiper    = seq_q.wiper;
    assign bus_deaf = (seq_q.mode != SEQ_STANDBY);
    assign nv_busy  = (seq_q.mode == SEQ_NVCYCLE);
endmodule

// File: rtl/nv_recall_seq_chk.sv
`timescale 1ns/1ps
module nv_recall_seq_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          vol_load,
    input logic [DW-1:0] vol_data,
    input logic          nv_start,
    input logic [DW-1:0] wiper,
    input logic [DW-1:0] stored,
    input logic          bus_deaf,
    input logic          nv_busy
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    // R2
    powerup_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_deaf && !nv_busy) |-> (wiper == MID));

    // R5
    busy_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> bus_deaf);

    // R5
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(nv_start));

    // R5
    stored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> ($stable(stored) || !nv_busy));

    // R7
    wiper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && supply_ok) |=> $stable(wiper));

    // R4
    vol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_deaf && vol_load && supply_ok) |=> (wiper == $past(vol_data)));

    // R8
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (bus_deaf && !nv_busy && wiper == MID));

    // R3
    recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_deaf) && !$past(nv_busy)) |-> (wiper == stored));
endmodule

bind nv_recall_seq nv_recall_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .vol_load  (vol_load),
    .vol_data  (vol_data),
    .nv_start  (nv_start),
    .wiper     (wiper),
    .stored    (stored),
    .bus_deaf  (bus_deaf),
    .nv_busy   (nv_busy)
);

// File: tb/test_nv_recall_seq.sv
`timescale 1ns/1ps
module test_nv_recall_seq;
    localparam int DW  = 8;
    localparam int PWR = 5;
    localparam int NV  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          vol_load = 1'b0;
    logic [DW-1:0] vol_data = '0;
    logic          nv_start = 1'b0;
    logic [DW-1:0] nv_data = '0;
    logic [DW-1:0] wiper, stored;
    logic          bus_deaf, nv_busy;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    nv_recall_seq #(.DW(DW), .PWR_CYCLES(PWR), .NV_CYCLES(NV)) i_nv_recall_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .vol_load(vol_load), .vol_data(vol_data),
        .nv_start(nv_start), .nv_data(nv_data),
        .wiper(wiper), .stored(stored), .bus_deaf(bus_deaf), .nv_busy(nv_busy)
    );

    // Behavioural reference: 0 = waiting for supply, 1 = standby, 2 = storing
    int m_mode = 0, m_wiper = 128, m_store = 128, m_pend = 0, m_seen = 0, m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_wiper = 128; m_store = 128; m_seen = 0; m_left = 0;
        end else if (!supply_ok) begin
            m_mode = 0; m_wiper = 128; m_seen = 0; m_left = 0;
        end else if (m_mode == 0) begin
            m_seen++;
            if (m_seen >= PWR) begin m_mode = 1; m_wiper = m_store; end
        end else if (m_mode == 1) begin
            if (vol_load) m_wiper = vol_data;
            if (nv_start) begin m_mode = 2; m_left = NV; m_pend = nv_data; end
        end else begin
            m_left--;
            if (m_left == 0) begin m_store = m_pend; m_mode = 1; end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (wiper != m_wiper || stored != m_store ||
                bus_deaf != (m_mode != 1) || nv_busy != (m_mode == 2)) begin
                errors++;
                $display("FAIL %s per-cycle: actual w=%0h s=%0h d=%0b b=%0b expected w=%0h s=%0h d=%0b b=%0b",
                         tag, wiper, stored, bus_deaf, nv_busy,
                         m_wiper, m_store, (m_mode != 1), (m_mode == 2));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && nv_busy; i++) tick(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int hi;
        tick(3);
        chk("R1 wiper", wiper, 8'h80);
        chk("R1 stored", stored, 8'h80);
        chk("R1 bus_deaf", bus_deaf, 1);
        chk("R1 nv_busy", nv_busy, 0);
        rst_n = 1'b1;
        tick(1);

        tag = "R2";
        vol_load = 1; vol_data = 8'h11; nv_start = 1; nv_data = 8'h22;
        tick(1);
        vol_load = 0; nv_start = 0;
        tick(2);
        chk("R2 wiper", wiper, 8'h80);
        chk("R2 stored", stored, 8'h80);
        chk("R2 bus_deaf", bus_deaf, 1);

        tag = "R3";
        supply_ok = 1; tick(3); supply_ok = 0; tick(1);
        chk("R3 broken window", bus_deaf, 1);
        supply_ok = 1; tick(PWR - 1);
        chk("R3 one edge short", bus_deaf, 1);
        tick(1);
        chk("R3 released", bus_deaf, 0);
        chk("R3 recall", wiper, 8'h80);

        tag = "R4";
        vol_load = 1; vol_data = 8'h3C; tick(1); vol_load = 0;
        chk("R4 wiper", wiper, 8'h3C);
        chk("R4 stored", stored, 8'h80);
        chk("R4 no busy", nv_busy, 0);

        tag = "R5";
        nv_start = 1; nv_data = 8'hA5; tick(1); nv_start = 0;
        chk("R5 stored before end", stored, 8'h80);
        hi = 0;
        while (nv_busy && hi < 100) begin hi++; tick(1); end
        chk("R5 busy length", hi, NV);
        tag = "R6";
        chk("R6 stored", stored, 8'hA5);
        chk("R6 wiper", wiper, 8'h3C);

        tag = "R7";
        nv_start = 1; nv_data = 8'h02; tick(1); nv_start = 0;
        tick(2);
        vol_load = 1; vol_data = 8'h01; nv_start = 1; nv_data = 8'h44;
        tick(1);
        vol_load = 0; nv_start = 0;
        chk("R7 wiper held", wiper, 8'h3C);
        wait_idle();
        chk("R7 first capture kept", stored, 8'h02);

        tag = "R9";
        vol_load = 1; vol_data = 8'h5A; nv_start = 1; nv_data = 8'hC3;
        tick(1);
        vol_load = 0; nv_start = 0;
        chk("R9 wiper", wiper, 8'h5A);
        wait_idle();
        chk("R9 stored", stored, 8'hC3);

        tag = "R6";
        vol_load = 1; vol_data = 8'h00; nv_start = 1; nv_data = 8'hFF;
        tick(1);
        vol_load = 0; nv_start = 0;
        wait_idle();
        chk("R6 wiper zero", wiper, 8'h00);
        chk("R6 stored full", stored, 8'hFF);

        tag = "R8";
        nv_start = 1; nv_data = 8'h77; tick(1); nv_start = 0;
        tick(3);
        supply_ok = 0; tick(1);
        chk("R8 wiper mid", wiper, 8'h80);
        chk("R8 deaf", bus_deaf, 1);
        chk("R8 not busy", nv_busy, 0);
        tick(NV + 2);
        chk("R8 stored kept", stored, 8'hFF);
        supply_ok = 1; tick(PWR);
        chk("R8 recall deaf", bus_deaf, 0);
        chk("R8 recall wiper", wiper, 8'hFF);

        tick(2);
        finish_run();
    end
endmodule